// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a small byte-addressed memory. A host drives chip select, serial clock and serial data in; the block returns data on a serial output with a separate output-enable, so the pad can float when nothing is being read. It oversamples all serial pins with the system clock, sees clock edges as pulses, and runs one state machine for each chip-select window. Each window starts with a one-byte instruction. Accepted instructions are set write latch (0x06), clear write latch (0x04), read status (0x05), write status (0x01), read array (0x03) and write array (0x02).

A volatile status byte holds a status-lock bit, a two-bit protection level and the write latch. Array writes and status writes need the write latch. Array writes are also filtered by the protection level. A status write is refused while the status-lock bit is set and the write-protect pin is low. The array is reached through a synchronous byte-wide port: a one-cycle read request returns data on the next cycle, and a one-cycle write strobe stores a byte.

States and transitions:
- `ST_IDLE` is held while chip select is high. It moves to `ST_OPCODE` when chip select falls.
- After the first byte, `ST_OPCODE` branches as follows:
  - read status goes to `ST_STAT_OUT`.
  - write status goes to `ST_STAT_IN`.
  - read array or write array goes to `ST_ADDR_HI`.
  - set write latch, clear write latch and any unknown code go to `ST_SKIP`.
- `ST_ADDR_HI` moves to `ST_ADDR_LO`. `ST_ADDR_LO` moves to `ST_RD_DATA` or `ST_WR_DATA`.
- `ST_STAT_IN` moves to `ST_SKIP` after its data byte.
- `ST_RD_DATA`, `ST_WR_DATA`, `ST_STAT_OUT` and `ST_SKIP` hold until chip select rises. Any state returns to `ST_IDLE` when chip select rises.

Top module: `spi_mem_slave`

## Requirements
- R1: Both clock polarities work: idle-low (mode 0) and idle-high (mode 3). Input bits are taken on rising serial clock edges and output bits change on falling edges. Bytes go most significant bit first in both directions.
- R2: The status byte reads as {lock, 0, 0, 0, level[1], level[0], wel, 0}, with bit 7 the status-lock bit and bit 1 the write latch. Bits 6 to 4 and bit 0 always read 0. After reset the whole byte is 0x00.
- R3: Instruction 0x06 sets the write latch and 0x04 clears it.
- R4: Instruction 0x01 followed by a data byte loads the status-lock bit from data bit 7 and the protection level from data bits 3:2. The load happens only when the write latch is set. Otherwise the status byte is unchanged.
- R5: While the status-lock bit is 1 and wp_n is low, a status write leaves the status byte unchanged. With wp_n high, or with the lock bit 0, the status write is accepted.
- R6: When chip select rises to end a write-array or write-status transaction that began with the write latch set, the write latch reads 0 afterwards. This holds even if the write itself was refused.
- R7: Instruction 0x03 is followed by a two-byte address, high byte first. Address bit 15 is ignored. Data bytes then stream from consecutive addresses, and address 0x7FFF is followed by 0x0000.
- R8: Instruction 0x02 uses the same address format and auto-increment as R7. It stores each following byte only when the write latch is set. Otherwise memory is unchanged.
- R9: The protection level selects which addresses refuse writes. Level 00 protects nothing. Level 01 protects 0x6000 to 0x7FFF. Level 10 protects 0x4000 to 0x7FFF. Level 11 protects every address. Writes to protected addresses are discarded.
- R10: After an unknown first byte, the rest of the transaction has no effect. miso_oe stays low until chip select rises.
- R11: miso_oe is high only during the data phase of a read-status or read-array transaction. It is low during reset, during instruction and address bytes, during writes and while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for miso; low means high impedance |
| mem_addr | output | 15 | Byte address for the memory port |
| mem_re | output | 1 | One-cycle read request |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte returned one cycle after mem_re |

## Verification
Every serial pin passes through a two-flop synchronizer. Each serial-clock edge therefore takes effect three system clocks after it reaches the pins. A byte's effect on the write latch, status byte or memory port lands one cycle after that edge. The write-latch clear lands about four clocks after chip select rises. A read byte is requested three cycles after the last address bit and is held in the block two cycles later, well before the next falling edge loads it. The bench holds each serial-clock level for eight system clocks and samples miso, miso_oe and all read-back results at falling system-clock edges just before it raises the serial clock. It waits two half periods after raising chip select, so every result is settled before it is observed.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_ARR  = 8'h03;
    localparam logic [7:0] OP_WR_ARR  = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_SKIP
    } xfer_state_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int           W   = 4,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar g;
    for (g = 0; g < W; g++) begin : g_bit
        logic meta, stable;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta   <= RST[g];
                stable <= RST[g];
            end else begin
                meta   <= d[g];
                stable <= meta;
            end
        end
        assign q[g] = stable;
    end
endmodule

// File: rtl/spi_mem_prot.sv
module spi_mem_prot #(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    always_comb begin
        unique case (level)
            2'b00: locked = 1'b0;
            2'b01: locked = (addr[ADDR_W-1 -: 2] == 2'b11);
            2'b10: locked = addr[ADDR_W-1];
            2'b11: locked = 1'b1;
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              wp_n,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int HI_W = ADDR_W - 8;

    // synchronized pins: {wp_n, mosi, sck, cs_n}
    logic [3:0] pins_s;
    logic       cs_s, sck_s, mosi_s, wp_s;

    spi_mem_sync #(.W(4), .RST(4'b1001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wp_n, mosi, sck, cs_n}),
        .q     (pins_s)
    );
    assign {wp_s, mosi_s, sck_s, cs_s} = pins_s;

    xfer_state_t state, state_nx;

    logic              sck_q, cs_q;
    logic              sck_rise, sck_fall, cs_rise;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sr;
    logic [7:0]        rx_byte, tx_sr, rd_buf, status_byte;
    logic              byte_done, tx_live, re_d, is_rd;
    logic              lock_bit, wel, wel_clr_pend;
    logic [1:0]        level;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_locked;

    assign sck_rise    = sck_s & ~sck_q & ~cs_s;
    assign sck_fall    = ~sck_s & sck_q & ~cs_s;
    assign cs_rise     = cs_s & ~cs_q;
    assign byte_done   = sck_rise && (bit_cnt == 3'd7);
    assign rx_byte     = {rx_sr, mosi_s};
    assign status_byte = {lock_bit, 3'b000, level, wel, 1'b0};
    assign miso        = tx_sr[7];
    assign miso_oe     = tx_live;

    spi_mem_prot #(.ADDR_W(ADDR_W)) u_prot (
        .level  (level),
        .addr   (cur_addr),
        .locked (cur_locked)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (cs_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_OPCODE;
                ST_OPCODE:
                    if (byte_done) begin
                        case (rx_byte)
                            OP_RD_STAT:           state_nx = ST_STAT_OUT;
                            OP_WR_STAT:           state_nx = ST_STAT_IN;
                            OP_RD_ARR, OP_WR_ARR: state_nx = ST_ADDR_HI;
                            default:              state_nx = ST_SKIP;
                        endcase
                    end
                ST_ADDR_HI: if (byte_done) state_nx = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_done) state_nx = is_rd ? ST_RD_DATA : ST_WR_DATA;
                ST_STAT_IN: if (byte_done) state_nx = ST_SKIP;
                ST_RD_DATA, ST_WR_DATA, ST_STAT_OUT, ST_SKIP: state_nx = state;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q        <= 1'b0;
            cs_q         <= 1'b1;
            bit_cnt      <= '0;
            rx_sr        <= '0;
            tx_sr        <= '0;
            tx_live      <= 1'b0;
            rd_buf       <= '0;
            re_d         <= 1'b0;
            is_rd        <= 1'b0;
            lock_bit     <= 1'b0;
            level        <= 2'b00;
            wel          <= 1'b0;
            wel_clr_pend <= 1'b0;
            addr_hi      <= '0;
            cur_addr     <= '0;
            mem_addr     <= '0;
            mem_re       <= 1'b0;
            mem_we       <= 1'b0;
            mem_wdata    <= '0;
        end else begin
            sck_q  <= sck_s;
            cs_q   <= cs_s;
            mem_re <= 1'b0;
            mem_we <= 1'b0;
            re_d   <= mem_re;
            if (re_d) rd_buf <= mem_rdata;

            if (cs_s) begin
                bit_cnt      <= '0;
                tx_live      <= 1'b0;
                wel_clr_pend <= 1'b0;
                if (cs_rise && wel_clr_pend) wel <= 1'b0;
            end else begin
                if (sck_rise) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    rx_sr   <= rx_byte[6:0];
                end
                if (byte_done) begin
                    case (state)
                        ST_OPCODE: begin
                            if (rx_byte == OP_SET_WEL) wel <= 1'b1;
                            if (rx_byte == OP_CLR_WEL) wel <= 1'b0;
                            is_rd <= (rx_byte == OP_RD_ARR);
                            if ((rx_byte == OP_WR_STAT || rx_byte == OP_WR_ARR) && wel)
                                wel_clr_pend <= 1'b1;
                        end
                        ST_ADDR_HI: addr_hi <= rx_byte[HI_W-1:0];
                        ST_ADDR_LO: begin
                            cur_addr <= {addr_hi, rx_byte};
                            if (is_rd) begin
                                mem_addr <= {addr_hi, rx_byte};
                                mem_re   <= 1'b1;
                            end
                        end
                        ST_RD_DATA: begin
                            cur_addr <= cur_addr + 1'b1;
                            mem_addr <= cur_addr + 1'b1;
                            mem_re   <= 1'b1;
                        end
                        ST_WR_DATA: begin
                            mem_we    <= wel && !cur_locked;
                            mem_addr  <= cur_addr;
                            mem_wdata <= rx_byte;
                            cur_addr  <= cur_addr + 1'b1;
                        end
                        ST_STAT_IN: begin
                            if (wel && !(lock_bit && !wp_s)) begin
                                lock_bit <= rx_byte[7];
                                level    <= rx_byte[3:2];
                            end
                        end
                        default: ;
                    endcase
                end
                if (sck_fall) begin
                    if (bit_cnt == 3'd0 && (state == ST_RD_DATA || state == ST_STAT_OUT)) begin
                        tx_sr   <= (state == ST_RD_DATA) ? rd_buf : status_byte;
                        tx_live <= 1'b1;
                    end else begin
                        tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R11: output enabled only in a read data phase
    assert_oe_only_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (state == ST_RD_DATA || state == ST_STAT_OUT));

    // R10: a skipped transaction never drives the output
    assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !miso_oe);

    // R8: a memory write strobe needs the latch from the cycle before
    assert_we_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wel));

    // R9: no strobe reaches a protected address
    assert_no_full_lock_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (level != 2'b11));
    assert_no_quarter_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && level == 2'b01) |-> (mem_addr[ADDR_W-1 -: 2] != 2'b11));
    assert_no_half_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && level == 2'b10) |-> !mem_addr[ADDR_W-1]);

    // R5: hardware lock freezes the status fields
    assert_hw_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_bit && !wp_s) |=> $stable({lock_bit, level}));

    // R6: latch drops when a write transaction ends
    assert_wel_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && wel_clr_pend) |=> !wel);

endmodule

// File: tb/sim_spi_mem_slave.sv
`timescale 1ns/1ps
module sim_spi_mem_slave;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_oe, mem_re, mem_we;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int  n_chk = 0, n_fail = 0;
    bit  mode3 = 1'b0;
    bit  oe_seen;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    spi_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
        .miso(miso), .miso_oe(miso_oe), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // sparse memory model: 256 bytes indexed by address bits 14:13 and 5:0
    logic [7:0] mem [256];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_re) mem_rdata <= mem[{mem_addr[14:13], mem_addr[5:0]}];
            if (mem_we) mem[{mem_addr[14:13], mem_addr[5:0]}] <= mem_wdata;
        end
    end

    // {set latch first, wp_n, status data, expected status}
    localparam logic [17:0] VEC [6] = '{
        {1'b1, 1'b1, 8'h8C, 8'h8C},
        {1'b1, 1'b0, 8'h00, 8'h8C},
        {1'b1, 1'b1, 8'h04, 8'h04},
        {1'b0, 1'b1, 8'h08, 8'h04},
        {1'b1, 1'b0, 8'hF3, 8'h80},
        {1'b1, 1'b1, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck  = 1'b0;
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            if (miso_oe) oe_seen = 1'b1;
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic sel();
        sck     = mode3;
        oe_seen = 1'b0;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        sel(); xbyte(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] d;
        sel(); xbyte(8'h05, d); xbyte(8'h00, st); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xbyte(8'h01, d); xbyte(v, d); desel();
    endtask

    task automatic wr_bytes(input logic [15:0] a, input logic [23:0] data, input int n);
        logic [7:0] d;
        sel(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
        for (int k = 0; k < n; k++) xbyte(data[23-8*k -: 8], d);
        desel();
    endtask

    task automatic rd_bytes(input logic [15:0] a, input int n, output logic [23:0] data);
        logic [7:0] d;
        data = '0;
        sel(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, d);
            data[23-8*k -: 8] = d;
        end
        desel();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  st;
        logic [23:0] rd;
        logic [7:0]  d;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        check("R11 reset oe", {23'd0, miso_oe}, 24'd0);
        rdsr(st);
        check("R2 reset status", {16'd0, st}, 24'h000000);

        cmd(8'h06); rdsr(st);
        check("R3 set latch", {16'd0, st}, 24'h000002);
        cmd(8'h04); rdsr(st);
        check("R3 clear latch", {16'd0, st}, 24'h000000);

        wr_bytes(16'h0120, 24'h550000, 1);
        rd_bytes(16'h0120, 1, rd);
        check("R8 write without latch", rd, 24'h000000);

        cmd(8'h06);
        wr_bytes(16'h0010, 24'hA1A2A3, 3);
        check("R11 oe during write", {23'd0, oe_seen}, 24'd0);
        rdsr(st);
        check("R6 latch dropped after write", {16'd0, st}, 24'h000000);
        rd_bytes(16'h0010, 3, rd);
        check("R7 R8 burst readback", rd, 24'hA1A2A3);
        check("R11 oe during read", {23'd0, oe_seen}, 24'd1);
        check("R11 oe after deselect", {23'd0, miso_oe}, 24'd0);

        // R1: idle-high clock
        mode3 = 1'b1;
        rd_bytes(16'h8010, 1, rd);
        check("R1 R7 mode 3 read, bit 15 ignored", rd, 24'hA10000);
        cmd(8'h06);
        wr_bytes(16'h7FFF, 24'h5A6B00, 2);
        rd_bytes(16'h7FFF, 2, rd);
        check("R7 wrap at top", rd, 24'h5A6B00);
        rd_bytes(16'h0000, 1, rd);
        check("R7 wrap landed at zero", rd, 24'h6B0000);
        rdsr(st);
        check("R1 mode 3 status", {16'd0, st}, 24'h000000);
        mode3 = 1'b0;

        // status write vectors: R4 R5 R6
        foreach (VEC[i]) begin
            if (VEC[i][17]) cmd(8'h06);
            wp_n = VEC[i][16];
            wrsr(VEC[i][15:8]);
            wp_n = 1'b1;
            rdsr(st);
            check($sformatf("R4 R5 R6 status vector %0d", i), {16'd0, st}, {16'd0, VEC[i][7:0]});
        end

        // R9 protection levels
        cmd(8'h06); wrsr(8'h04);
        cmd(8'h06); wr_bytes(16'h5FFF, 24'hC1C200, 2);
        rd_bytes(16'h5FFF, 2, rd);
        check("R9 upper quarter", rd, 24'hC10000);
        cmd(8'h06); wrsr(8'h08);
        cmd(8'h06); wr_bytes(16'h3FFF, 24'hD1D200, 2);
        rd_bytes(16'h3FFF, 2, rd);
        check("R9 upper half", rd, 24'hD10000);
        cmd(8'h06); wrsr(8'h0C);
        cmd(8'h06); wr_bytes(16'h0010, 24'hEE0000, 1);
        rd_bytes(16'h0010, 1, rd);
        check("R9 whole array", rd, 24'hA10000);
        rdsr(st);
        check("R9 level readback", {16'd0, st}, 24'h00000C);

        // R10 unknown opcode
        sel();
        xbyte(8'hAB, d); xbyte(8'h06, d); xbyte(8'h05, d); xbyte(8'h00, d);
        desel();
        check("R10 oe stays low", {23'd0, oe_seen}, 24'd0);
        rdsr(st);
        check("R10 status untouched", {16'd0, st}, 24'h00000C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule